// File: doc/BRIEF.md
# Frame Relocation Mode Sequencer

This block is the top-level sequencer of a frame relocation engine. It is given a two-bit operation code, a source region address, a destination region address, a supplied destination frame address and a start strobe. It then runs a frame-by-frame handshake with two neighbouring units. The first is a frame address generator, which turns a region into a stream of frame address pairs. The second is a relocator, which moves one frame per request. The block also drives the control inputs of a frame buffer: a held reset, a write/read select and a step strobe. It contains the buffer's own word-address counter, which steps forward by itself.

The operation code picks the route for each transfer. Relocate sends each generated source frame straight to the generated destination frame, and the buffer stays in reset. Copy moves generated source frames into consecutive buffer words. Configure moves consecutive buffer words to the supplied destination frame address. Reset holds all three neighbours in reset, and it is meant to be issued between changes of the other codes. The configuration port, the storage array and the frame datapath are outside the block. They are reached only through the ports listed below.

The state machine has seven states:
- `ST_IDLE`: waits for start.
- `ST_LAUNCH`: asks the generator for its first pair.
- `ST_WAIT_PAIR`: waits for a pair.
- `ST_KICK`: issues the relocator request.
- `ST_XFER`: waits for relocator done.
- `ST_ADVANCE`: acknowledges the generator and steps the buffer.
- `ST_FINISH`: raises region-complete.

Its transitions are:
- idle→launch: start with a non-reset code.
- launch→wait.
- wait→kick: a pair arrives.
- kick→xfer.
- xfer→advance: relocator done.
- advance→wait: the pair was not the last one.
- advance→finish: the pair was the last one.
- finish→idle.

Top module: `reloc_seq_top`

## Requirements
- R1: The mode register resets to code 00 (reset mode). While the mode is 00, `gen_rst`, `rel_rst` and `buf_rst` are all 1, `buf_addr` is 0, `busy` is 0, and both relocator addresses and both select outputs are 0.
- R2: A start accepted while idle loads `mode_in` into the mode register, with 00 = reset, 01 = relocate, 10 = copy and 11 = configure. `rel_mode` presents the stored code from the next cycle on.
- R3: In relocate mode, `rel_src_addr` = `gen_src_fa` and `rel_dst_addr` = `gen_dst_fa`. Both selects are 0 (generator), and `buf_rst` stays 1.
- R4: In copy mode, `buf_wr` = 1 and `buf_rst` = 0. The source is `gen_src_fa` with `rel_src_sel` = 0. The destination is `buf_addr`, zero-extended, with `rel_dst_sel` = 1.
- R5: In configure mode, `buf_wr` = 0 and `buf_rst` = 0. The source is `buf_addr`, zero-extended, with `rel_src_sel` = 1. The destination is `cfg_frame_addr` with `rel_dst_sel` = 2.
- R6: A start with a non-reset code, accepted while idle, does three things. It makes `busy` 1 from the next cycle. It gives a single `gen_start` pulse in that cycle. It latches `src_region` and `dst_region` onto `gen_src_region` and `gen_dst_region`.
- R7: One cycle after `gen_pair_valid` is sampled while the block is waiting for a pair, `rel_start` pulses for one cycle. `gen_pair_valid` is ignored at any other time.
- R8: One cycle after `rel_done` is sampled during a transfer, `gen_go` pulses for one cycle. `buf_go` pulses with it in copy and configure modes, and never in relocate mode.
- R9: `buf_addr` increases by one for each `buf_go` and wraps from BUF_DEPTH-1 to 0. It becomes 0 on every accepted start, and it is held at 0 while `buf_rst` is 1.
- R10: The `gen_last` value captured with a pair decides what follows that pair's `gen_go`. If it was 1, `region_done` pulses once in the next cycle and the block returns to idle. If it was 0, the block waits for the next pair.
- R11: A start or a change of `mode_in` while `busy` is 1 has no effect. The mode, the routing and the sequence continue unchanged.
- R12: At most one of `gen_start`, `rel_start`, `gen_go` and `region_done` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_in | input | 2 | Requested operation code |
| start | input | 1 | Start strobe, taken only while idle |
| src_region | input | REGION_W | Source region address |
| dst_region | input | REGION_W | Destination region address |
| cfg_frame_addr | input | FRAME_W | Supplied destination frame address for configure |
| gen_pair_valid | input | 1 | Generator has a new frame address pair |
| gen_last | input | 1 | The presented pair is the region's last |
| gen_src_fa | input | FRAME_W | Generated source frame address |
| gen_dst_fa | input | FRAME_W | Generated destination frame address |
| rel_done | input | 1 | Relocator finished the current frame |
| gen_rst | output | 1 | Generator held in reset |
| gen_start | output | 1 | Generator begin pulse |
| gen_go | output | 1 | Generator acknowledge / next pair request |
| gen_src_region | output | REGION_W | Latched source region |
| gen_dst_region | output | REGION_W | Latched destination region |
| rel_rst | output | 1 | Relocator held in reset |
| rel_mode | output | 2 | Relocator operation code |
| rel_start | output | 1 | Relocator frame request |
| rel_src_sel | output | 1 | Source mux select: 0 generator, 1 buffer |
| rel_dst_sel | output | 2 | Destination mux select: 0 generator, 1 buffer, 2 supplied |
| rel_src_addr | output | XA_W | Routed source address |
| rel_dst_addr | output | XA_W | Routed destination address |
| buf_rst | output | 1 | Buffer held in reset |
| buf_wr | output | 1 | Buffer write (1) or read (0) |
| buf_go | output | 1 | Buffer address step strobe |
| buf_addr | output | BAW | Buffer word address |
| busy | output | 1 | Operation in progress |
| region_done | output | 1 | Region-complete pulse |

## Verification
The bench aims at the point where the last pair is completed. A design that read `gen_last` when it was not qualified would end early or never end, because the bench changes that line on every cycle while no pair is valid. Copy runs that are longer than a shrunken buffer check the wrap back to zero. A configure run straight after a copy checks that the address restarts at zero; a design that kept the old address would send the wrong words. A start issued in the middle of an operation with a different code checks that the routing does not switch in the middle of a region. Generator pairs that arrive while the block is not waiting for one check that no extra relocator request is issued.

// File: rtl/reloc_seq_pkg.sv
package reloc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_RESET  = 2'b00,
        MODE_RELOC  = 2'b01,
        MODE_COPY   = 2'b10,
        MODE_CONFIG = 2'b11
    } op_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT_PAIR,
        ST_KICK,
        ST_XFER,
        ST_ADVANCE,
        ST_FINISH
    } seq_state_t;

    typedef enum logic {
        SRC_GEN = 1'b0,
        SRC_BUF = 1'b1
    } src_sel_t;

    typedef enum logic [1:0] {
        DST_GEN = 2'b00,
        DST_BUF = 2'b01,
        DST_CFG = 2'b10
    } dst_sel_t;

endpackage

// File: rtl/reloc_seq_fsm.sv
module reloc_seq_fsm
    import reloc_seq_pkg::*;
#(
    parameter int REGION_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  op_mode_t            mode_req,
    input  logic [REGION_W-1:0] src_region_in,
    input  logic [REGION_W-1:0] dst_region_in,
    input  logic                pair_valid,
    input  logic                pair_last,
    input  logic                xfer_done,
    output op_mode_t            mode_q,
    output logic [REGION_W-1:0] src_region_q,
    output logic [REGION_W-1:0] dst_region_q,
    output logic                gen_start,
    output logic                rel_start,
    output logic                gen_go,
    output logic                buf_go,
    output logic                region_done,
    output logic                busy,
    output logic                cnt_clear
);

    seq_state_t state, state_nx;
    logic       last_q;
    logic       accept;

    assign accept = (state == ST_IDLE) && start;

    // state register and captured operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            mode_q       <= MODE_RESET;
            last_q       <= 1'b0;
            src_region_q <= '0;
            dst_region_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                mode_q       <= mode_req;
                src_region_q <= src_region_in;
                dst_region_q <= dst_region_in;
            end
            if ((state == ST_WAIT_PAIR) && pair_valid) begin
                last_q <= pair_last;
            end
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (accept && (mode_req != MODE_RESET)) state_nx = ST_LAUNCH;
            ST_LAUNCH:    state_nx = ST_WAIT_PAIR;
            ST_WAIT_PAIR: if (pair_valid) state_nx = ST_KICK;
            ST_KICK:      state_nx = ST_XFER;
            ST_XFER:      if (xfer_done) state_nx = ST_ADVANCE;
            ST_ADVANCE:   state_nx = last_q ? ST_FINISH : ST_WAIT_PAIR;
            ST_FINISH:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        gen_start   = 1'b0;
        rel_start   = 1'b0;
        gen_go      = 1'b0;
        buf_go      = 1'b0;
        region_done = 1'b0;
        busy        = (state != ST_IDLE);
        cnt_clear   = accept;
        unique case (state)
            ST_IDLE:      ;
            ST_LAUNCH:    gen_start = 1'b1;
            ST_WAIT_PAIR: ;
            ST_KICK:      rel_start = 1'b1;
            ST_XFER:      ;
            ST_ADVANCE: begin
                gen_go = 1'b1;
                buf_go = (mode_q == MODE_COPY) || (mode_q == MODE_CONFIG);
            end
            ST_FINISH:    region_done = 1'b1;
            default:      ;
        endcase
    end

    // R12: handshake strobes never overlap
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gen_start, rel_start, gen_go, region_done}));

    // R7: a relocator request only follows a presented pair
    a_r7_kick_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_start) |-> $past(pair_valid));

    // R10: completion only directly after a generator acknowledge
    a_r10_done_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        region_done |-> $past(gen_go));

    // R11: the stored mode does not move while an operation runs
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(mode_q));

endmodule

// File: rtl/reloc_buf_addr.sv
module reloc_buf_addr #(
    parameter  int DEPTH = 16384,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          clear,
    input  logic          step,
    output logic [AW-1:0] addr_q
);

    localparam bit POW2 = (DEPTH == (1 << AW));

    logic [AW-1:0] addr_nx;

    generate
        if (POW2) begin : g_wrap_free
            assign addr_nx = addr_q + 1'b1;
        end else begin : g_wrap_cmp
            assign addr_nx = (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (hold || clear) begin
            addr_q <= '0;
        end else if (step) begin
            addr_q <= addr_nx;
        end
    end

    // R9: one word per step, wrapping at the top of the buffer
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hold && !clear) |=>
            (addr_q == (($past(addr_q) == AW'(DEPTH - 1)) ? '0 : $past(addr_q) + 1'b1)));

    // R9: held or cleared means zero next cycle
    a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hold || clear) |=> (addr_q == '0));

endmodule

// File: rtl/reloc_route.sv
module reloc_route
    import reloc_seq_pkg::*;
#(
    parameter int FRAME_W = 23,
    parameter int BAW     = 14,
    parameter int XA_W    = 23
) (
    input  op_mode_t           mode,
    input  logic [FRAME_W-1:0] gen_src,
    input  logic [FRAME_W-1:0] gen_dst,
    input  logic [FRAME_W-1:0] cfg_dst,
    input  logic [BAW-1:0]     buf_addr,
    output src_sel_t           src_sel,
    output dst_sel_t           dst_sel,
    output logic [XA_W-1:0]    src_addr,
    output logic [XA_W-1:0]    dst_addr
);

    logic [XA_W-1:0] buf_ext;

    generate
        if (XA_W > BAW) begin : g_buf_pad
            assign buf_ext = {{(XA_W - BAW){1'b0}}, buf_addr};
        end else begin : g_buf_same
            assign buf_ext = buf_addr[XA_W-1:0];
        end
    endgenerate

    always_comb begin
        src_sel  = SRC_GEN;
        dst_sel  = DST_GEN;
        src_addr = '0;
        dst_addr = '0;
        unique case (mode)
            MODE_RESET: ;
            MODE_RELOC: begin
                src_addr = XA_W'(gen_src);
                dst_addr = XA_W'(gen_dst);
            end
            MODE_COPY: begin
                src_addr = XA_W'(gen_src);
                dst_sel  = DST_BUF;
                dst_addr = buf_ext;
            end
            MODE_CONFIG: begin
                src_sel  = SRC_BUF;
                src_addr = buf_ext;
                dst_sel  = DST_CFG;
                dst_addr = XA_W'(cfg_dst);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/reloc_seq_top.sv
module reloc_seq_top
    import reloc_seq_pkg::*;
#(
    parameter  int REGION_W  = 24,
    parameter  int FRAME_W   = 23,
    parameter  int BUF_DEPTH = 16384,
    localparam int BAW       = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
    localparam int XA_W      = (FRAME_W > BAW) ? FRAME_W : BAW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_in,
    input  logic                start,
    input  logic [REGION_W-1:0] src_region,
    input  logic [REGION_W-1:0] dst_region,
    input  logic [FRAME_W-1:0]  cfg_frame_addr,
    input  logic                gen_pair_valid,
    input  logic                gen_last,
    input  logic [FRAME_W-1:0]  gen_src_fa,
    input  logic [FRAME_W-1:0]  gen_dst_fa,
    input  logic                rel_done,
    output logic                gen_rst,
    output logic                gen_start,
    output logic                gen_go,
    output logic [REGION_W-1:0] gen_src_region,
    output logic [REGION_W-1:0] gen_dst_region,
    output logic                rel_rst,
    output logic [1:0]          rel_mode,
    output logic                rel_start,
    output logic                rel_src_sel,
    output logic [1:0]          rel_dst_sel,
    output logic [XA_W-1:0]     rel_src_addr,
    output logic [XA_W-1:0]     rel_dst_addr,
    output logic                buf_rst,
    output logic                buf_wr,
    output logic                buf_go,
    output logic [BAW-1:0]      buf_addr,
    output logic                busy,
    output logic                region_done
);

    op_mode_t mode_q;
    logic     cnt_clear;
    logic     buf_hold;
    src_sel_t src_sel;
    dst_sel_t dst_sel;

    reloc_seq_fsm #(
        .REGION_W (REGION_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mode_req     (op_mode_t'(mode_in)),
        .src_region_in(src_region),
        .dst_region_in(dst_region),
        .pair_valid   (gen_pair_valid),
        .pair_last    (gen_last),
        .xfer_done    (rel_done),
        .mode_q       (mode_q),
        .src_region_q (gen_src_region),
        .dst_region_q (gen_dst_region),
        .gen_start    (gen_start),
        .rel_start    (rel_start),
        .gen_go       (gen_go),
        .buf_go       (buf_go),
        .region_done  (region_done),
        .busy         (busy),
        .cnt_clear    (cnt_clear)
    );

    // the buffer sits in reset outside copy and configure
    assign buf_hold = (mode_q == MODE_RESET) || (mode_q == MODE_RELOC);

    reloc_buf_addr #(
        .DEPTH (BUF_DEPTH)
    ) u_buf_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (buf_hold),
        .clear  (cnt_clear),
        .step   (buf_go),
        .addr_q (buf_addr)
    );

    reloc_route #(
        .FRAME_W (FRAME_W),
        .BAW     (BAW),
        .XA_W    (XA_W)
    ) u_route (
        .mode     (mode_q),
        .gen_src  (gen_src_fa),
        .gen_dst  (gen_dst_fa),
        .cfg_dst  (cfg_frame_addr),
        .buf_addr (buf_addr),
        .src_sel  (src_sel),
        .dst_sel  (dst_sel),
        .src_addr (rel_src_addr),
        .dst_addr (rel_dst_addr)
    );

    assign gen_rst     = (mode_q == MODE_RESET);
    assign rel_rst     = (mode_q == MODE_RESET);
    assign buf_rst     = buf_hold;
    assign buf_wr      = (mode_q == MODE_COPY);
    assign rel_mode    = mode_q;
    assign rel_src_sel = src_sel;
    assign rel_dst_sel = dst_sel;

    // R3: a relocate pass never leaves the buffer active
    a_r3_buf_reset_reloc: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_mode == 2'b01) |-> buf_rst);

    // R8: no buffer step during relocate
    a_r8_no_step_reloc: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_mode == 2'b01) |-> !buf_go);

    // R1: nothing is busy or strobing while in reset mode
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_mode == 2'b00) |-> (!busy && !gen_go && !rel_start && buf_addr == '0));

endmodule

// File: tb/reloc_seq_top_test.sv
module reloc_seq_top_test;

    localparam int REGION_W = 24;
    localparam int FRAME_W  = 23;
    localparam int DEPTH    = 8;
    localparam int BAW      = 3;
    localparam int XA_W     = 23;
    localparam int PERIOD   = 20;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          mode_in = 2'b00;
    logic                start = 1'b0;
    logic [REGION_W-1:0] src_region = '0;
    logic [REGION_W-1:0] dst_region = '0;
    logic [FRAME_W-1:0]  cfg_frame_addr = '0;
    logic                gen_pair_valid = 1'b0;
    logic                gen_last = 1'b0;
    logic [FRAME_W-1:0]  gen_src_fa = '0;
    logic [FRAME_W-1:0]  gen_dst_fa = '0;
    logic                rel_done = 1'b0;
    logic                gen_rst, gen_start, gen_go, rel_rst, rel_start, rel_src_sel;
    logic [REGION_W-1:0] gen_src_region, gen_dst_region;
    logic [1:0]          rel_mode, rel_dst_sel;
    logic [XA_W-1:0]     rel_src_addr, rel_dst_addr;
    logic                buf_rst, buf_wr, buf_go, busy, region_done;
    logic [BAW-1:0]      buf_addr;

    always #(PERIOD / 2) clk = ~clk;

    reloc_seq_top #(
        .REGION_W (REGION_W),
        .FRAME_W  (FRAME_W),
        .BUF_DEPTH(DEPTH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .start(start),
        .src_region(src_region), .dst_region(dst_region),
        .cfg_frame_addr(cfg_frame_addr), .gen_pair_valid(gen_pair_valid),
        .gen_last(gen_last), .gen_src_fa(gen_src_fa), .gen_dst_fa(gen_dst_fa),
        .rel_done(rel_done), .gen_rst(gen_rst), .gen_start(gen_start),
        .gen_go(gen_go), .gen_src_region(gen_src_region),
        .gen_dst_region(gen_dst_region), .rel_rst(rel_rst), .rel_mode(rel_mode),
        .rel_start(rel_start), .rel_src_sel(rel_src_sel), .rel_dst_sel(rel_dst_sel),
        .rel_src_addr(rel_src_addr), .rel_dst_addr(rel_dst_addr),
        .buf_rst(buf_rst), .buf_wr(buf_wr), .buf_go(buf_go), .buf_addr(buf_addr),
        .busy(busy), .region_done(region_done)
    );

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;

    // behavioural reference: phase of the protocol, stored code, buffer word
    int m_ph = 0;
    int m_mode = 0;
    int m_addr = 0;
    int m_last = 0;
    int m_sreg = 0;
    int m_dreg = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_mode = 0; m_addr = 0; m_last = 0; m_sreg = 0; m_dreg = 0;
        end else begin
            automatic bit held = (m_mode <= 1);
            case (m_ph)
                0: if (start) begin
                    m_mode = int'(mode_in);
                    m_sreg = int'(src_region);
                    m_dreg = int'(dst_region);
                    m_addr = 0;
                    if (mode_in != 2'b00) m_ph = 1;
                end
                1: m_ph = 2;
                2: if (gen_pair_valid) begin m_last = int'(gen_last); m_ph = 3; end
                3: m_ph = 4;
                4: if (rel_done) m_ph = 5;
                5: begin
                    if (m_mode >= 2) m_addr = (m_addr + 1) % DEPTH;
                    m_ph = (m_last != 0) ? 6 : 2;
                end
                default: m_ph = 0;
            endcase
            if (held) m_addr = 0;
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        longint es, ed;
        int ss, ds;
        string rt;
        es = 0; ed = 0; ss = 0; ds = 0;
        case (m_mode)
            1: begin es = gen_src_fa; ed = gen_dst_fa; rt = "R3 route"; end
            2: begin es = gen_src_fa; ed = m_addr; ds = 1; rt = "R4 route"; end
            3: begin es = m_addr; ed = cfg_frame_addr; ss = 1; ds = 2; rt = "R5 route"; end
            default: rt = "R1 route";
        endcase
        chk("R2 rel_mode", rel_mode, m_mode);
        chk("R6 busy", busy, m_ph != 0);
        chk("R6 gen_start", gen_start, m_ph == 1);
        chk("R6 gen_src_region", gen_src_region, m_sreg);
        chk("R6 gen_dst_region", gen_dst_region, m_dreg);
        chk("R7 rel_start", rel_start, m_ph == 3);
        chk("R8 gen_go", gen_go, m_ph == 5);
        chk("R8 buf_go", buf_go, (m_ph == 5) && (m_mode >= 2));
        chk("R10 region_done", region_done, m_ph == 6);
        chk("R9 buf_addr", buf_addr, m_addr);
        chk("R1 gen_rst", gen_rst, m_mode == 0);
        chk("R1 rel_rst", rel_rst, m_mode == 0);
        chk("R3 buf_rst", buf_rst, m_mode <= 1);
        chk("R4 buf_wr", buf_wr, m_mode == 2);
        chk({rt, " src"}, rel_src_addr, es);
        chk({rt, " dst"}, rel_dst_addr, ed);
        chk({rt, " src_sel"}, rel_src_sel, ss);
        chk({rt, " dst_sel"}, rel_dst_sel, ds);
        chk("R12 strobes", ($countones({gen_start, rel_start, gen_go, region_done}) <= 1), 1);
    endtask

    // generator and relocator stand-ins
    int n_frames = 0, g_dly = 1, r_dly = 1;
    int issued = 0, gcnt = 0, rcnt = 0;

    task automatic step();
        @(negedge clk);
        cyc++;
        if (rst_n) compare_all();
        gen_pair_valid = 1'b0;
        rel_done       = 1'b0;
        gen_last       = cyc[0];
        gen_src_fa     = FRAME_W'(32'h0012_3400 ^ (cyc * 7));
        gen_dst_fa     = FRAME_W'(32'h0045_6700 ^ (cyc * 13));
        cfg_frame_addr = FRAME_W'(32'h0007_0000 + cyc);
        if (gcnt > 0) begin
            gcnt--;
            if (gcnt == 0) begin
                gen_pair_valid = 1'b1;
                gen_last       = (issued == n_frames - 1);
                issued++;
            end
        end
        if (gen_start) begin issued = 0; gcnt = g_dly; end
        else if (gen_go && issued < n_frames) gcnt = g_dly;
        if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) rel_done = 1'b1;
        end
        if (rel_start) rcnt = r_dly;
        // a stray pair while not waiting must be ignored (R7)
        if (!gen_pair_valid && gcnt == 0 && busy && (cyc % 5 == 0)) begin
            gen_pair_valid = (rcnt > 0);
            gen_last       = 1'b1;
        end
    endtask

    task automatic run_op(int code, int n, int gd, int rd, int poke);
        n_frames = n; g_dly = gd; r_dly = rd;
        mode_in    = 2'(code);
        src_region = REGION_W'(32'h00A0_0000 + code * 16 + n);
        dst_region = REGION_W'(32'h00B0_0000 + code * 32 + n);
        start = 1'b1;
        step();
        start = 1'b0;
        mode_in = 2'(code ^ 1);
        if (code != 0) begin
            for (int k = 0; k < 400; k++) begin
                if (k == poke) begin
                    start   = 1'b1;           // R11: ignored while busy
                    mode_in = 2'(code ^ 3);
                    src_region = '1;
                end
                step();
                start = 1'b0;
                if (k > poke && poke > 0 && k < poke + 3)
                    chk("R11 mode kept", rel_mode, code);
                if (region_done) break;
            end
        end
        step();
        step();
        chk("R10 back to idle", busy, 0);
    endtask

    initial begin
        #(PERIOD * 190000);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step(); step();
        // R1 reset-state checks come from compare_all in these cycles
        chk("R1 buf_addr after reset", buf_addr, 0);
        run_op(1, 3, 1, 2, 0);   // relocate
        run_op(0, 0, 1, 1, 0);   // reset mode
        run_op(2, 5, 2, 1, 0);   // copy
        run_op(3, 4, 1, 3, 0);   // configure straight after copy: address restarts
        run_op(2, 11, 1, 1, 0);  // copy past the buffer end: wrap (R9)
        run_op(0, 0, 1, 1, 0);
        run_op(1, 2, 3, 2, 4);   // mid-operation start poke (R11)
        run_op(3, 1, 1, 1, 0);   // single-frame configure (R10)
        run_op(0, 0, 1, 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule